// File: doc/BRIEF.md
# Write Fault Status Capture

This block records faults on the peripheral bus in a status word and a fault address word. The bus interface side reports two kinds of error: a late error, which comes after a transfer has already ended, and an error acknowledge returned to a write. Each report comes with the attributes of the transfer that caused it: the transfer size, whether it was a read, whether the processor was in supervisor mode, and the address. A built-in write timer watches each outstanding write. If the write has not completed after `TIMEOUT_CYC` clock cycles, the timer raises a timeout fault. For example, 320 cycles at 25 MHz gives 12.8 µs.

The first fault loads the full context. A fault that arrives while a fault is already held sets only a sticky multiple-fault flag. Software reads the two words and then clears flags by writing ones to them. A single interrupt line stays high while any fault flag is held.

The write timer is a two-state machine. `TMR_IDLE` goes to `TMR_RUN` on transition START. `TMR_RUN` stays in `TMR_RUN` on RESTART, which is a new write. It goes back to `TMR_IDLE` on FINISH, when the write completes, or on EXPIRE, when the timeout fires. The fault log is also a two-state machine. `LOG_EMPTY` goes to `LOG_HELD` on CAPTURE. `LOG_HELD` stays in `LOG_HELD` on KEEP, when flags remain and there is no new fault. It also stays on STACK, when flags remain and a new fault arrives, and on RELOAD, when a clear empties the flags in the same cycle as a new fault. `LOG_HELD` goes to `LOG_EMPTY` on DRAIN, when the flags are emptied and no fault arrives.

Top module: `wfault_capture`

## Requirements
- R1: After reset, `fault_status` reads 0x0080_0000, `fault_addr` reads 0 and `fault_irq` is low.
- R2: `fault_status[31]` is 1 exactly when at least one of bits 30, 29 or 28 is 1. `fault_irq` equals `fault_status[31]`.
- R3: A `bus_err_late` pulse sampled while the log is empty sets `fault_status[30]` from the next cycle on.
- R4: A `bus_err_ack` pulse sampled while the log is empty sets `fault_status[28]` from the next cycle on.
- R5: A write started by `wr_start` at clock edge E, with no `wr_done` and no new `wr_start` on edges E+1 to E+TIMEOUT_CYC, raises a timeout at edge E+TIMEOUT_CYC. If the log is empty, this sets `fault_status[29]`. The context is then the size, supervisor bit and address sampled with `wr_start`, and the read bit is 0. A `wr_done` sampled at or before edge E+TIMEOUT_CYC prevents the timeout.
- R6: A `wr_start` sampled while a write is outstanding restarts the timeout window from that edge, and the earlier write can no longer time out.
- R7: The first fault loads size into bits 27:25, supervisor into bit 24 and read into bit 18. It sets bit 17 (address valid) and loads `fault_addr`. If a bus error and a timeout occur in the same cycle, the bus attributes are loaded.
- R8: A fault that arrives while a flag in bits 30:28 is still held sets only bit 19. The other flags, the context fields and `fault_addr` stay unchanged.
- R9: `fault_status[23:20]` always reads 0x8, and bits 16:0 always read 0.
- R10: A `sw_clr_we` write clears flags bit by bit: a 1 in bit 31 clears all flags, and a 1 in bit 30, 29, 28 or 19 clears that flag. All other bits of `sw_clr_data` are ignored. When no flag in bits 30:28 remains and no fault arrives, the log returns to its reset value.
- R11: A fault in the same cycle as a clear is applied after the clear. If no flag in bits 30:28 survives the clear, the fault is captured as a first fault with bit 19 at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_err_late | input | 1 | Error reported after a transfer completed |
| bus_err_ack | input | 1 | Error acknowledge received by a write |
| xfer_size | input | 3 | Transfer size code |
| xfer_rd | input | 1 | Transfer is a read |
| xfer_sup | input | 1 | Processor in supervisor mode |
| xfer_addr | input | AW | Transfer physical address |
| wr_start | input | 1 | A write is issued; starts or restarts the timer |
| wr_done | input | 1 | The outstanding write completed |
| sw_clr_we | input | 1 | Software write strobe to the status word |
| sw_clr_data | input | 32 | Write-one-to-clear data |
| fault_status | output | 32 | Fault status word |
| fault_addr | output | AW | Address of the first fault |
| fault_irq | output | 1 | High while any fault flag is held |

## Verification
The collision the bench provokes most deliberately is a software clear and a fresh fault in the same clock. This is tested both with a clear that empties every flag and with a clear that leaves a flag held. The first case must reload the context from the new fault and leave bit 19 at 0. The second must only set bit 19. A second race puts the completion of a write on exactly the timeout edge, and then a bus error on a timeout edge. In those cases the bench looks for no timeout at all, and then for bus attributes in the context. Every cycle, a behavioural model in the bench predicts both output words and judges the design against them.

// File: rtl/wf_pkg.sv
package wf_pkg;

    typedef enum logic {
        TMR_IDLE,
        TMR_RUN
    } tmr_state_t;

    typedef enum logic {
        LOG_EMPTY,
        LOG_HELD
    } log_state_t;

    typedef struct packed {
        logic [2:0] size;
        logic       sup;
        logic       rd;
    } xfer_ctx_t;

    localparam int unsigned STAT_W   = 32;
    localparam logic [3:0]  RSVD_VAL = 4'h8;

    // bit positions of the write-one-to-clear controls
    localparam int unsigned B_SUM   = 31;
    localparam int unsigned B_LATE  = 30;
    localparam int unsigned B_TMO   = 29;
    localparam int unsigned B_ACK   = 28;
    localparam int unsigned B_MULTI = 19;

endpackage

// File: rtl/wf_write_timer.sv
module wf_write_timer
    import wf_pkg::*;
#(
    parameter int unsigned LIMIT = 320,
    parameter int unsigned AW    = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_start,
    input  logic          wr_done,
    input  logic [2:0]    st_size,
    input  logic          st_sup,
    input  logic [AW-1:0] st_addr,
    output logic          to_evt,
    output logic [2:0]    to_size,
    output logic          to_sup,
    output logic [AW-1:0] to_addr
);

    localparam int unsigned CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    tmr_state_t    state, state_n;
    logic [CW-1:0] cnt, cnt_n;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= TMR_IDLE;
            cnt     <= '0;
            to_size <= '0;
            to_sup  <= 1'b0;
            to_addr <= '0;
        end else begin
            state <= state_n;
            cnt   <= cnt_n;
            if (wr_start) begin
                to_size <= st_size;
                to_sup  <= st_sup;
                to_addr <= st_addr;
            end
        end
    end

    // transitions and outputs
    always_comb begin
        to_evt  = (state == TMR_RUN) && (cnt == LAST) && !wr_start && !wr_done;
        state_n = state;
        cnt_n   = cnt;
        unique case (state)
            TMR_IDLE: begin
                if (wr_start) begin            // START
                    state_n = TMR_RUN;
                    cnt_n   = '0;
                end
            end
            TMR_RUN: begin
                if (wr_start) begin            // RESTART
                    cnt_n = '0;
                end else if (wr_done || to_evt) begin  // FINISH / EXPIRE
                    state_n = TMR_IDLE;
                end else begin
                    cnt_n = cnt + 1'b1;
                end
            end
        endcase
    end

endmodule

// File: rtl/wf_fault_log.sv
module wf_fault_log
    import wf_pkg::*;
#(
    parameter int unsigned AW = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_late,
    input  logic              ev_ack,
    input  logic              ev_to,
    input  logic [2:0]        bus_size,
    input  logic              bus_sup,
    input  logic              bus_rd,
    input  logic [AW-1:0]     bus_addr,
    input  logic [2:0]        tmo_size,
    input  logic              tmo_sup,
    input  logic [AW-1:0]     tmo_addr,
    input  logic              clr_we,
    input  logic              clr_all,
    input  logic              clr_late,
    input  logic              clr_tmo,
    input  logic              clr_ack,
    input  logic              clr_multi,
    output logic [STAT_W-1:0] status,
    output logic [AW-1:0]     addr,
    output logic              irq
);

    log_state_t    state, state_n;
    logic          f_late, f_tmo, f_ack, f_multi;
    logic          n_late, n_tmo, n_ack, n_multi;
    xfer_ctx_t     ctx, ctx_n, new_ctx;
    logic [AW-1:0] addr_n, new_addr;
    logic          k_late, k_tmo, k_ack, k_multi, held, evt, bus_src;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= LOG_EMPTY;
            f_late  <= 1'b0;
            f_tmo   <= 1'b0;
            f_ack   <= 1'b0;
            f_multi <= 1'b0;
            ctx     <= '0;
            addr    <= '0;
        end else begin
            state   <= state_n;
            f_late  <= n_late;
            f_tmo   <= n_tmo;
            f_ack   <= n_ack;
            f_multi <= n_multi;
            ctx     <= ctx_n;
            addr    <= addr_n;
        end
    end

    // transitions
    always_comb begin
        k_late  = f_late  & ~(clr_we & (clr_all | clr_late));
        k_tmo   = f_tmo   & ~(clr_we & (clr_all | clr_tmo));
        k_ack   = f_ack   & ~(clr_we & (clr_all | clr_ack));
        k_multi = f_multi & ~(clr_we & (clr_all | clr_multi));
        held    = k_late | k_tmo | k_ack;
        evt     = ev_late | ev_ack | ev_to;
        bus_src = ev_late | ev_ack;

        new_ctx.size = bus_src ? bus_size : tmo_size;
        new_ctx.sup  = bus_src ? bus_sup  : tmo_sup;
        new_ctx.rd   = bus_src & bus_rd;
        new_addr     = bus_src ? bus_addr : tmo_addr;

        state_n = state;
        n_late  = f_late;
        n_tmo   = f_tmo;
        n_ack   = f_ack;
        n_multi = f_multi;
        ctx_n   = ctx;
        addr_n  = addr;

        unique case (state)
            LOG_EMPTY: begin
                if (evt) begin                 // CAPTURE
                    state_n = LOG_HELD;
                    n_late  = ev_late;
                    n_tmo   = ev_to;
                    n_ack   = ev_ack;
                    n_multi = 1'b0;
                    ctx_n   = new_ctx;
                    addr_n  = new_addr;
                end
            end
            LOG_HELD: begin
                if (held) begin                // KEEP / STACK
                    n_late  = k_late;
                    n_tmo   = k_tmo;
                    n_ack   = k_ack;
                    n_multi = k_multi | evt;
                end else if (evt) begin        // RELOAD
                    n_late  = ev_late;
                    n_tmo   = ev_to;
                    n_ack   = ev_ack;
                    n_multi = 1'b0;
                    ctx_n   = new_ctx;
                    addr_n  = new_addr;
                end else begin                 // DRAIN
                    state_n = LOG_EMPTY;
                    n_late  = 1'b0;
                    n_tmo   = 1'b0;
                    n_ack   = 1'b0;
                    n_multi = 1'b0;
                    ctx_n   = '0;
                    addr_n  = '0;
                end
            end
        endcase
    end

    // outputs
    always_comb begin
        irq    = f_late | f_tmo | f_ack;
        status = {irq, f_late, f_tmo, f_ack, ctx.size, ctx.sup, RSVD_VAL,
                  f_multi, ctx.rd, (state == LOG_HELD), 17'b0};
    end

endmodule

// File: rtl/wfault_capture.sv
module wfault_capture
    import wf_pkg::*;
#(
    parameter int unsigned AW          = 32,
    parameter int unsigned TIMEOUT_CYC = 320
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_err_late,
    input  logic              bus_err_ack,
    input  logic [2:0]        xfer_size,
    input  logic              xfer_rd,
    input  logic              xfer_sup,
    input  logic [AW-1:0]     xfer_addr,
    input  logic              wr_start,
    input  logic              wr_done,
    input  logic              sw_clr_we,
    input  logic [STAT_W-1:0] sw_clr_data,
    output logic [STAT_W-1:0] fault_status,
    output logic [AW-1:0]     fault_addr,
    output logic              fault_irq
);

    logic          to_evt;
    logic [2:0]    to_size;
    logic          to_sup;
    logic [AW-1:0] to_addr;
    logic          clr_unused;

    assign clr_unused = ^{sw_clr_data[27:20], sw_clr_data[18:0]};

    wf_write_timer #(
        .LIMIT (TIMEOUT_CYC),
        .AW    (AW)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_start (wr_start),
        .wr_done  (wr_done),
        .st_size  (xfer_size),
        .st_sup   (xfer_sup),
        .st_addr  (xfer_addr),
        .to_evt   (to_evt),
        .to_size  (to_size),
        .to_sup   (to_sup),
        .to_addr  (to_addr)
    );

    wf_fault_log #(
        .AW (AW)
    ) u_log (
        .clk       (clk),
        .rst_n     (rst_n),
        .ev_late   (bus_err_late),
        .ev_ack    (bus_err_ack),
        .ev_to     (to_evt),
        .bus_size  (xfer_size),
        .bus_sup   (xfer_sup),
        .bus_rd    (xfer_rd),
        .bus_addr  (xfer_addr),
        .tmo_size  (to_size),
        .tmo_sup   (to_sup),
        .tmo_addr  (to_addr),
        .clr_we    (sw_clr_we),
        .clr_all   (sw_clr_data[B_SUM]),
        .clr_late  (sw_clr_data[B_LATE]),
        .clr_tmo   (sw_clr_data[B_TMO]),
        .clr_ack   (sw_clr_data[B_ACK]),
        .clr_multi (sw_clr_data[B_MULTI]),
        .status    (fault_status),
        .addr      (fault_addr),
        .irq       (fault_irq)
    );

endmodule

// File: rtl/wf_capture_chk.sv
module wf_capture_chk #(
    parameter int unsigned AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bus_err_late,
    input logic          bus_err_ack,
    input logic [AW-1:0] xfer_addr,
    input logic          sw_clr_we,
    input logic [31:0]   fault_status,
    input logic [AW-1:0] fault_addr
);

    // R3
    late_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_err_late && !fault_status[17]) |=> (fault_status[30] && fault_status[17]));

    // R4
    ack_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_err_ack && !fault_status[17]) |=> (fault_status[28] && fault_status[17]));

    // R7
    first_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!fault_status[17] && (bus_err_late || bus_err_ack)) |=> (fault_addr == $past(xfer_addr)));

    // R8
    later_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_status[17] && !sw_clr_we) |=> ($stable(fault_addr) && $stable(fault_status[27:24])));

    // R8
    later_multi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_status[17] && !sw_clr_we && (bus_err_late || bus_err_ack)) |=> fault_status[19]);

    // R10
    empty_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fault_status[31] |-> (fault_status[19:17] == 3'b000 && fault_addr == '0));

endmodule

bind wfault_capture wf_capture_chk #(.AW(AW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_err_late (bus_err_late),
    .bus_err_ack  (bus_err_ack),
    .xfer_addr    (xfer_addr),
    .sw_clr_we    (sw_clr_we),
    .fault_status (fault_status),
    .fault_addr   (fault_addr)
);

// File: tb/test_wfault_capture.sv
`timescale 1ns/1ps
module test_wfault_capture;

    localparam int TO = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_err_late = 1'b0, bus_err_ack = 1'b0;
    logic [2:0]  xfer_size = '0;
    logic        xfer_rd = 1'b0, xfer_sup = 1'b0;
    logic [31:0] xfer_addr = '0;
    logic        wr_start = 1'b0, wr_done = 1'b0;
    logic        sw_clr_we = 1'b0;
    logic [31:0] sw_clr_data = '0;
    logic [31:0] fault_status, fault_addr;
    logic        fault_irq;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    wfault_capture #(.AW(32), .TIMEOUT_CYC(TO)) i_wfault_capture (
        .clk(clk), .rst_n(rst_n), .bus_err_late(bus_err_late), .bus_err_ack(bus_err_ack),
        .xfer_size(xfer_size), .xfer_rd(xfer_rd), .xfer_sup(xfer_sup), .xfer_addr(xfer_addr),
        .wr_start(wr_start), .wr_done(wr_done), .sw_clr_we(sw_clr_we), .sw_clr_data(sw_clr_data),
        .fault_status(fault_status), .fault_addr(fault_addr), .fault_irq(fault_irq)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // behavioural reference model
    bit m_le, m_to, m_be, m_me, m_fav, m_rd, m_sup, m_busy, live;
    bit [2:0] m_size, t_size;
    bit t_sup;
    bit [31:0] m_addr, t_addr;
    int m_age;

    always @(posedge clk) begin
        bit tev, held, evt;
        if (!rst_n) begin
            {m_le, m_to, m_be, m_me, m_fav, m_rd, m_sup, m_busy} = '0;
            m_size = 0; m_addr = 0; m_age = 0;
        end else begin
            tev = m_busy && !wr_start && !wr_done && (m_age == TO);
            if (sw_clr_we) begin
                if (sw_clr_data[31]) {m_le, m_to, m_be, m_me} = '0;
                if (sw_clr_data[30]) m_le = 0;
                if (sw_clr_data[29]) m_to = 0;
                if (sw_clr_data[28]) m_be = 0;
                if (sw_clr_data[19]) m_me = 0;
            end
            held = m_le || m_to || m_be;
            evt = bus_err_late || bus_err_ack || tev;
            if (held) begin
                if (evt) m_me = 1;
            end else if (evt) begin
                m_le = bus_err_late; m_be = bus_err_ack; m_to = tev; m_me = 0; m_fav = 1;
                if (bus_err_late || bus_err_ack) begin
                    m_size = xfer_size; m_sup = xfer_sup; m_rd = xfer_rd; m_addr = xfer_addr;
                end else begin
                    m_size = t_size; m_sup = t_sup; m_rd = 0; m_addr = t_addr;
                end
            end else begin
                {m_me, m_fav, m_rd, m_sup} = '0; m_size = 0; m_addr = 0;
            end
            if (wr_start) begin
                m_busy = 1; m_age = 1; t_size = xfer_size; t_sup = xfer_sup; t_addr = xfer_addr;
            end else if (m_busy) begin
                if (wr_done || tev) m_busy = 0;
                else m_age++;
            end
        end
        live = 1;
    end

    // compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (live && rst_n) begin
            chk("R2 summary", {31'b0, fault_status[31]}, {31'b0, m_le | m_to | m_be});
            chk("R2 irq", {31'b0, fault_irq}, {31'b0, m_le | m_to | m_be});
            chk("R3 late flag", {31'b0, fault_status[30]}, {31'b0, m_le});
            chk("R5 timeout flag", {31'b0, fault_status[29]}, {31'b0, m_to});
            chk("R4 ack flag", {31'b0, fault_status[28]}, {31'b0, m_be});
            chk("R7 context", {25'b0, fault_status[27:24], fault_status[18:17]},
                {25'b0, m_size, m_sup, m_rd, m_fav});
            chk("R8 multi flag", {31'b0, fault_status[19]}, {31'b0, m_me});
            chk("R9 fixed fields", {fault_status[23:20], fault_status[16:0]}, {4'h8, 17'b0});
            chk("R7 address", fault_addr, m_addr);
        end
    end

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_attr(logic [2:0] sz, logic rd, logic sup, logic [31:0] a);
        xfer_size = sz; xfer_rd = rd; xfer_sup = sup; xfer_addr = a;
    endtask

    task automatic clr(logic [31:0] d);
        sw_clr_we = 1; sw_clr_data = d; cyc(1); sw_clr_we = 0; sw_clr_data = '0;
    endtask

    task automatic run_seq();
        cyc(3); rst_n = 1; cyc(1);
        chk("R1 reset status", fault_status, 32'h0080_0000);
        chk("R1 reset addr", fault_addr, 32'h0);
        chk("R1 reset irq", {31'b0, fault_irq}, 32'h0);

        // first late error
        set_attr(3'd3, 1, 1, 32'h1234_5670); bus_err_late = 1; cyc(1); bus_err_late = 0;
        chk("R3 R7 first capture", fault_status, 32'hC786_0000);
        // later ack error: multi only
        set_attr(3'd1, 0, 0, 32'hDEAD_0000); bus_err_ack = 1; cyc(1); bus_err_ack = 0;
        chk("R8 later keeps address", fault_addr, 32'h1234_5670);
        chk("R8 later sets multi only", fault_status, 32'hC78E_0000);
        // ignored clear bits
        clr(32'h0FF6_FFFF);
        chk("R10 ignored clear bits", fault_status, 32'hC78E_0000);
        clr(32'h0008_0000);
        chk("R10 clear multi", fault_status, 32'hC786_0000);
        clr(32'h4000_0000);
        chk("R10 drain status", fault_status, 32'h0080_0000);
        chk("R10 drain addr", fault_addr, 32'h0);

        // write completes early
        set_attr(3'd2, 0, 1, 32'hA000_0040); wr_start = 1; cyc(1); wr_start = 0;
        cyc(4); wr_done = 1; cyc(1); wr_done = 0; cyc(25);
        chk("R5 completed write no timeout", fault_status, 32'h0080_0000);
        // completion on the deadline edge
        wr_start = 1; cyc(1); wr_start = 0; cyc(TO - 1);
        wr_done = 1; cyc(1); wr_done = 0; cyc(3);
        chk("R5 done at deadline", fault_status, 32'h0080_0000);
        // real timeout
        set_attr(3'd2, 1, 1, 32'hA000_0040); wr_start = 1; cyc(1); wr_start = 0;
        set_attr(3'd0, 0, 0, 32'h0); cyc(TO);
        chk("R5 timeout status", fault_status, 32'hA582_0000);
        chk("R5 timeout addr", fault_addr, 32'hA000_0040);
        clr(32'h8000_0000);

        // restart window
        set_attr(3'd4, 0, 0, 32'h0000_1000); wr_start = 1; cyc(1); wr_start = 0;
        cyc(14);
        set_attr(3'd5, 0, 0, 32'h0000_2000); wr_start = 1; cyc(1); wr_start = 0;
        cyc(5);
        chk("R6 old deadline passes", {31'b0, fault_status[29]}, 32'h0);
        cyc(15);
        chk("R6 new deadline fires", {31'b0, fault_status[29]}, 32'h1);
        chk("R6 new write addr", fault_addr, 32'h0000_2000);
        clr(32'h2000_0000);

        // clear and fault collide, log fully emptied
        set_attr(3'd1, 0, 0, 32'h0000_00A0); bus_err_late = 1; cyc(1); bus_err_late = 0;
        set_attr(3'd5, 1, 0, 32'h0000_00B0); bus_err_ack = 1;
        sw_clr_we = 1; sw_clr_data = 32'h8000_0000; cyc(1);
        bus_err_ack = 0; sw_clr_we = 0; sw_clr_data = '0;
        chk("R11 reload addr", fault_addr, 32'h0000_00B0);
        chk("R11 reload status", fault_status, 32'h9A86_0000);
        // clear leaves a flag held while a fault arrives
        set_attr(3'd7, 0, 1, 32'h0000_00C0); bus_err_late = 1;
        sw_clr_we = 1; sw_clr_data = 32'h0008_0000; cyc(1);
        bus_err_late = 0; sw_clr_we = 0; sw_clr_data = '0;
        chk("R11 partial clear stacks", fault_status, 32'h9A8E_0000);
        // simultaneous sources while held
        bus_err_late = 1; bus_err_ack = 1; cyc(1); bus_err_late = 0; bus_err_ack = 0;
        clr(32'h8000_0000);
        // simultaneous sources while empty
        set_attr(3'd6, 0, 0, 32'h0000_00D0); bus_err_late = 1; bus_err_ack = 1; cyc(1);
        bus_err_late = 0; bus_err_ack = 0;
        chk("R3 R4 both flags", fault_status[31:28], 4'hD);
        clr(32'h8000_0000);

        // timeout and bus error on the same edge
        set_attr(3'd7, 0, 1, 32'hB000_0000); wr_start = 1; cyc(1); wr_start = 0;
        cyc(TO - 1);
        set_attr(3'd2, 0, 0, 32'hC000_0000); bus_err_late = 1; cyc(1); bus_err_late = 0;
        chk("R7 bus context wins", fault_addr, 32'hC000_0000);
        chk("R5 R7 both flags", fault_status, 32'hE482_0000);
        clr(32'h8000_0000);
        cyc(3);
    endtask

    initial begin
        fork
            run_seq();
            begin
                cyc(5000);
                errors++;
                $display("FAIL watchdog act=%0d exp=%0d", 5000, 0);
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule